// File: doc/BRIEF.md
# Linear Page Table Translator

This block is a translation unit for a paged memory system. It turns one virtual address at a time into a physical address. The page table is a flat array of 32-bit entries in ordinary memory, indexed by virtual page number. Software sets the array's starting address in a base register. For each request the unit forms the entry address and issues one read on its memory port. It waits as long as needed for the returned entry, then checks the entry in a fixed order: validity first, then the permission for the requested access type. The response carries either the physical address or a fault status.

Requests and responses use valid/ready handshakes, and only one translation is in flight at a time. A base-register write that arrives in the middle of a translation does not disturb it. The write is parked and applied once that translation has been handed back. By default the unit uses a 16-bit virtual space with 1 KB pages, which gives a 6-bit page number and a 10-bit offset. Physical addresses are 20 bits.

Top module: `lin_pt_xlate`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0 and mem_req_o is 0.
- R2: Each accepted request produces exactly one entry read, a one-cycle mem_req_o pulse issued before the response. Its address is base + 4 * VPN, where VPN is req_va_i[15:10].
- R3: An entry whose bit 0 (valid) is 0 ends the translation with status 1 (segmentation fault) and rsp_pa_o = 0.
- R4: For a valid entry, access code 0 (read) needs bit 1, code 1 (write) needs bit 2, and code 2 (execute) needs bit 3. Code 3 is never permitted. A missing permission gives status 2 (protection fault) and rsp_pa_o = 0.
- R5: The validity check comes first: an invalid entry reports status 1 even when all permission bits are set.
- R6: On success the status is 0 and rsp_pa_o is {frame, offset}. The frame is entry bits [17:8] and the offset is req_va_i[9:0], passed through unchanged. Entry bits 4 to 6 (present, dirty, referenced) have no effect on the result.
- R7: req_ready_o is 1 only while idle. A response stays valid, with stable address and status, until rsp_ready_i is seen, and no new request is accepted meanwhile.
- R8: A base write while idle applies to the next translation. A base write during a translation does not affect that translation and applies to the one after it.
- R9: The unit waits any number of cycles for mem_rvalid_i, including a response on the cycle right after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_va_i | input | 16 | Virtual address |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Result taken |
| rsp_pa_o | output | 20 | Physical address (0 on fault) |
| rsp_status_o | output | 2 | 0 ok, 1 segmentation fault, 2 protection fault |
| mem_req_o | output | 1 | Entry read request pulse |
| mem_addr_o | output | 20 | Entry byte address |
| mem_rvalid_i | input | 1 | Entry read data valid |
| mem_rdata_i | input | 32 | Entry read data |
| base_we_i | input | 1 | Base register write strobe |
| base_wdata_i | input | 20 | Base register write value |

## Verification
The assertions assume that the memory side returns exactly one mem_rvalid_i for each mem_req_o and never sends one unprompted. They also assume that req_va_i and req_acc_i are stable while a request waits for req_ready_o. The bench memory model answers each read once after a programmed delay. Its stimulus tasks hold the request fields constant until acceptance and drop req_valid_i right after it. Base writes are driven only on cycles that carry no new request, so the ordering of a write against an acceptance in the same cycle is never exercised.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned PTE_W   = 32;
  localparam int unsigned PTE_V   = 0;
  localparam int unsigned PTE_R   = 1;
  localparam int unsigned PTE_WR  = 2;
  localparam int unsigned PTE_X   = 3;
  localparam int unsigned PFN_LSB = 8;

  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_SEG   = 2'd1,
    ST_PROT  = 2'd2
  } xl_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_CHECK,
    S_RESP
  } xl_state_e;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int unsigned PA_W     = 20,
  parameter logic [PA_W-1:0] BASE_RST = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PA_W-1:0] wdata_i,
  input  logic            busy_i,
  output logic [PA_W-1:0] base_o,
  output logic            pend_o
);
  logic [PA_W-1:0] base_q, pdata_q;
  logic            pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= BASE_RST;
      pdata_q <= '0;
      pend_q  <= 1'b0;
    end else if (we_i && busy_i) begin
      pdata_q <= wdata_i;
      pend_q  <= 1'b1;
    end else if (we_i) begin
      // newest write wins over a parked one
      base_q <= wdata_i;
      pend_q <= 1'b0;
    end else if (pend_q && !busy_i) begin
      base_q <= pdata_q;
      pend_q <= 1'b0;
    end
  end

  assign base_o = base_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
  parameter int unsigned VA_W      = 16,
  parameter int unsigned OFFS_W    = 10,
  parameter int unsigned PA_W      = 20,
  parameter int unsigned PTE_BYTES = 4
) (
  input  logic [VA_W-1:0]        va_i,
  input  logic [PA_W-1:0]        base_i,
  input  logic [PA_W-OFFS_W-1:0] pfn_i,
  output logic [PA_W-1:0]        pte_addr_o,
  output logic [PA_W-1:0]        pa_o
);
  localparam int unsigned VPN_W  = VA_W - OFFS_W;
  localparam int unsigned PTE_SH = $clog2(PTE_BYTES);

  logic [VPN_W-1:0]  vpn;
  logic [OFFS_W-1:0] offs;
  logic [PA_W-1:0]   idx;

  assign vpn  = va_i[VA_W-1:OFFS_W];
  assign offs = va_i[OFFS_W-1:0];
  assign idx  = PA_W'(vpn) << PTE_SH;

  assign pte_addr_o = base_i + idx;
  assign pa_o       = {pfn_i, offs};
endmodule

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic [1:0]       acc_i,
  output xl_status_e       status_o
);
  logic allow;

  always_comb begin
    unique case (acc_i)
      ACC_RD:  allow = pte_i[PTE_R];
      ACC_WR:  allow = pte_i[PTE_WR];
      ACC_EX:  allow = pte_i[PTE_X];
      default: allow = 1'b0;
    endcase
  end

  // validity outranks permission
  always_comb begin
    if (!pte_i[PTE_V])  status_o = ST_SEG;
    else if (!allow)    status_o = ST_PROT;
    else                status_o = ST_OK;
  end
endmodule

// File: rtl/lin_pt_xlate.sv
module lin_pt_xlate
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W      = 16,
  parameter int unsigned OFFS_W    = 10,
  parameter int unsigned PA_W      = 20,
  parameter int unsigned PTE_BYTES = 4,
  parameter logic [PA_W-1:0] BASE_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [1:0]        req_acc_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic [1:0]        rsp_status_o,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  input  logic              base_we_i,
  input  logic [PA_W-1:0]   base_wdata_i
);
  localparam int unsigned PFN_W = PA_W - OFFS_W;

  xl_state_e        state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic [PTE_W-1:0] pte_q;
  logic [PA_W-1:0]  pa_q;
  xl_status_e       st_q;

  logic [PA_W-1:0]  base, pte_addr, pa_calc;
  logic             base_pend, busy, acc_fire;
  xl_status_e       st_calc;

  assign busy     = (state_q != S_IDLE);
  assign acc_fire = req_valid_i && req_ready_o;

  ptw_base_reg #(.PA_W(PA_W), .BASE_RST(BASE_RST)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (base_we_i),
    .wdata_i (base_wdata_i),
    .busy_i  (busy),
    .base_o  (base),
    .pend_o  (base_pend)
  );

  ptw_addr_calc #(
    .VA_W(VA_W), .OFFS_W(OFFS_W), .PA_W(PA_W), .PTE_BYTES(PTE_BYTES)
  ) u_addr (
    .va_i       (va_q),
    .base_i     (base),
    .pfn_i      (pte_q[PFN_LSB +: PFN_W]),
    .pte_addr_o (pte_addr),
    .pa_o       (pa_calc)
  );

  ptw_perm_chk u_perm (
    .pte_i    (pte_q),
    .acc_i    (acc_q),
    .status_o (st_calc)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (acc_fire)     state_d = S_FETCH;
      S_FETCH:                   state_d = S_WAIT;
      S_WAIT:  if (mem_rvalid_i) state_d = S_CHECK;
      S_CHECK:                   state_d = S_RESP;
      S_RESP:  if (rsp_ready_i)  state_d = S_IDLE;
      default:                   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      pte_q   <= '0;
      pa_q    <= '0;
      st_q    <= ST_OK;
    end else begin
      state_q <= state_d;
      if (acc_fire) begin
        va_q  <= req_va_i;
        acc_q <= req_acc_i;
      end
      if (state_q == S_WAIT && mem_rvalid_i) pte_q <= mem_rdata_i;
      if (state_q == S_CHECK) begin
        st_q <= st_calc;
        pa_q <= (st_calc == ST_OK) ? pa_calc : '0;
      end
    end
  end

  // parked base write drains in the idle cycle before the next request
  assign req_ready_o  = (state_q == S_IDLE) && !base_pend;
  assign mem_req_o    = (state_q == S_FETCH);
  assign mem_addr_o   = pte_addr;
  assign rsp_valid_o  = (state_q == S_RESP);
  assign rsp_pa_o     = pa_q;
  assign rsp_status_o = st_q;
endmodule

// File: rtl/lin_pt_xlate_chk.sv
module lin_pt_xlate_chk #(
  parameter int unsigned VA_W   = 16,
  parameter int unsigned OFFS_W = 10,
  parameter int unsigned PA_W   = 20
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [VA_W-1:0] req_va_i,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [PA_W-1:0] rsp_pa_o,
  input logic [1:0]      rsp_status_o,
  input logic            mem_req_o
);
  logic [VA_W-1:0] cap_va;
  logic [1:0]      rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_va <= '0;
      rd_cnt <= '0;
    end else if (req_valid_i && req_ready_o) begin
      cap_va <= req_va_i;
      rd_cnt <= '0;
    end else if (mem_req_o && rd_cnt != 2'd3) begin
      rd_cnt <= rd_cnt + 2'd1;
    end
  end

  a_r2_one_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rd_cnt == 2'd1);
  a_r2_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r3_fault_no_pa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o != 2'd0) |-> rsp_pa_o == '0);
  a_r6_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'd0) |-> rsp_pa_o[OFFS_W-1:0] == cap_va[OFFS_W-1:0]);
  a_r6_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_status_o != 2'd3);
  a_r7_single_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_req_o) |-> !req_ready_o);
  a_r7_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_status_o)));
endmodule

bind lin_pt_xlate lin_pt_xlate_chk #(.VA_W(VA_W), .OFFS_W(OFFS_W), .PA_W(PA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_va_i     (req_va_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_pa_o     (rsp_pa_o),
  .rsp_status_o (rsp_status_o),
  .mem_req_o    (mem_req_o)
);

// File: tb/sim_lin_pt_xlate.sv
module sim_lin_pt_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [15:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [19:0] rsp_pa;
  logic [1:0]  rsp_status;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        base_we = 1'b0;
  logic [19:0] base_wdata = '0;

  int total = 0, bad = 0;
  int mem_lat = 2;
  int mem_reads = 0;
  logic [19:0] last_addr = '0;
  logic [31:0] pt_mem [0:1023];
  logic        m_busy = 1'b0;
  int          m_cnt = 0;
  logic [19:0] m_addr = '0;

  always #5 clk = ~clk;

  lin_pt_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_acc_i(req_acc),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_pa_o(rsp_pa), .rsp_status_o(rsp_status),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .base_we_i(base_we), .base_wdata_i(base_wdata)
  );

  // entry memory with programmable latency
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      m_busy    <= 1'b1;
      m_cnt     <= mem_lat;
      m_addr    <= mem_addr;
      last_addr <= mem_addr;
      mem_reads <= mem_reads + 1;
    end else if (m_busy) begin
      if (m_cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= pt_mem[m_addr[11:2]];
        m_busy     <= 1'b0;
      end else begin
        m_cnt <= m_cnt - 1;
      end
    end
  end

  function automatic logic [31:0] pte(input int pfn, input logic [6:0] fl);
    return (32'(pfn) << 8) | 32'(fl);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic set_base(input logic [19:0] b);
    @(negedge clk);
    base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic send_req(input logic [15:0] va, input logic [1:0] acc);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic get_rsp(input int hold, output logic [19:0] pa, output logic [1:0] st);
    while (!rsp_valid) @(negedge clk);
    repeat (hold) @(negedge clk);
    pa = rsp_pa; st = rsp_status;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic xlate(input logic [15:0] va, input logic [1:0] acc,
                       output logic [19:0] pa, output logic [1:0] st);
    send_req(va, acc);
    get_rsp(0, pa, st);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
  endtask

  task automatic t_examples();
    logic [19:0] pa; logic [1:0] st; int n0;
    set_base(20'd1024);
    n0 = mem_reads;
    xlate(16'd1024, 2'd2, pa, st);
    chk(last_addr == 20'd1028, "R2 entry addr vpn1", last_addr, 1028);
    chk(mem_reads == n0 + 1, "R2 one read", mem_reads, n0 + 1);
    chk(st == 2'd0 && pa == 20'd4096, "R6 va1024", pa, 4096);
    xlate(16'd40000, 2'd1, pa, st);
    chk(last_addr == 20'd1180, "R2 entry addr vpn39", last_addr, 1180);
    chk(st == 2'd0 && pa == 20'd7232, "R6 va40000", pa, 7232);
    xlate(16'd45000, 2'd0, pa, st);
    chk(st == 2'd1, "R3 seg status", st, 1);
    chk(pa == 20'd0, "R3 seg pa", pa, 0);
  endtask

  task automatic t_perm();
    logic [19:0] pa; logic [1:0] st;
    xlate(16'(5 * 1024 + 17), 2'd0, pa, st);
    chk(st == 2'd0 && pa == 20'(12 * 1024 + 17), "R4 read allowed", pa, 12 * 1024 + 17);
    xlate(16'(5 * 1024), 2'd1, pa, st);
    chk(st == 2'd2 && pa == 0, "R4 write denied", st, 2);
    xlate(16'(5 * 1024), 2'd2, pa, st);
    chk(st == 2'd2, "R4 exec denied", st, 2);
    xlate(16'(5 * 1024), 2'd3, pa, st);
    chk(st == 2'd2, "R4 code3 denied", st, 2);
    xlate(16'(6 * 1024), 2'd0, pa, st);
    chk(st == 2'd2, "R4 read no R bit", st, 2);
    xlate(16'(6 * 1024 + 3), 2'd1, pa, st);
    chk(st == 2'd0 && pa == 20'(900 * 1024 + 3), "R4 write allowed", pa, 900 * 1024 + 3);
  endtask

  task automatic t_order();
    logic [19:0] pa; logic [1:0] st;
    xlate(16'(7 * 1024), 2'd0, pa, st);
    chk(st == 2'd1 && pa == 0, "R5 invalid wins", st, 1);
    xlate(16'(8 * 1024 + 1023), 2'd0, pa, st);
    chk(st == 2'd0 && pa == 20'(1023 * 1024 + 1023), "R6 flags ignored", pa, 1023 * 1024 + 1023);
  endtask

  task automatic t_latency();
    logic [19:0] pa; logic [1:0] st; int n0;
    mem_lat = 0;
    n0 = mem_reads;
    xlate(16'd1030, 2'd0, pa, st);
    chk(st == 2'd0 && pa == 20'd4102, "R9 zero latency", pa, 4102);
    mem_lat = 9;
    xlate(16'd1030, 2'd0, pa, st);
    chk(st == 2'd0 && pa == 20'd4102, "R9 long latency", pa, 4102);
    chk(mem_reads == n0 + 2, "R2 reads per xlate", mem_reads, n0 + 2);
    mem_lat = 2;
  endtask

  task automatic t_hold();
    logic [19:0] pa; logic [1:0] st; bit held;
    send_req(16'd40001, 2'd0);
    while (!rsp_valid) @(negedge clk);
    held = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!rsp_valid || req_ready || rsp_pa != 20'd7233) held = 1'b0;
    end
    chk(held, "R7 response held", held, 1);
    get_rsp(0, pa, st);
    chk(st == 2'd0 && pa == 20'd7233, "R7 held value", pa, 7233);
  endtask

  task automatic t_base();
    logic [19:0] pa; logic [1:0] st;
    mem_lat = 6;
    send_req(16'd1024, 2'd0);
    @(negedge clk);
    base_we = 1'b1; base_wdata = 20'd2048;
    @(negedge clk);
    base_we = 1'b0;
    get_rsp(0, pa, st);
    chk(last_addr == 20'd1028, "R8 in-flight uses old base", last_addr, 1028);
    chk(st == 2'd0 && pa == 20'd4096, "R8 in-flight result", pa, 4096);
    mem_lat = 2;
    xlate(16'd1024, 2'd0, pa, st);
    chk(last_addr == 20'd2052, "R8 parked write applied", last_addr, 2052);
    chk(st == 2'd0 && pa == 20'(50 * 1024), "R8 new table", pa, 50 * 1024);
    set_base(20'd1024);
    xlate(16'd1024, 2'd0, pa, st);
    chk(last_addr == 20'd1028, "R8 idle write", last_addr, 1028);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) pt_mem[i] = '0;
    pt_mem[257] = pte(4, 7'b000_1011);        // 1028: vpn1, V R X
    pt_mem[295] = pte(7, 7'b000_0111);        // 1180: vpn39, V R W
    pt_mem[256 + 5] = pte(12, 7'b000_0011);   // V R
    pt_mem[256 + 6] = pte(900, 7'b000_1101);  // V W X
    pt_mem[256 + 7] = pte(3, 7'b000_1110);    // invalid, all perms
    pt_mem[256 + 8] = pte(1023, 7'b111_0011); // V R + P D A
    pt_mem[513] = pte(50, 7'b000_0011);       // 2052: second table vpn1
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_examples();
    t_perm();
    t_order();
    t_latency();
    t_hold();
    t_base();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule